// File: doc/BRIEF.md
# Multi-Master DRAM Bank Crossbar

This block sits between a set of user ports and the per-bank command interfaces of a DRAM controller. Each user port presents a read or write command with a flat address. The crossbar takes the bank field out of that address and arbitrates among the ports that want the same bank. It then hands the remaining row and column bits to the chosen bank. A bank can hold a lock that keeps it tied to the port whose command it is holding. While the lock is high, competing ports wait.

Every command a bank accepts is recorded in a small in-order queue for that bank, tagged with the issuing port. The bank later pulses its write-data or read-data strobe. The crossbar pops the head of that bank's queue and delays the port tag by the fixed PHY latency. It then selects that port's write data and byte-enable onto the shared write bus, or flags that port as the receiver of the shared read bus. Each port carries a fixed permission to read, to write, or to do both. Commands it is not allowed to issue are never forwarded.

Top module: `dram_bank_xbar`

## Requirements
- R1: A port address is {row, bank, col_hi}, where col_hi is the column shifted right by BURST_ALIGN bits. The bank field therefore occupies bits [COL_BITS-BURST_ALIGN +: BANK_BITS]. The address sent to the bank is {row, col_hi} with the bank field removed.
- R2: A bank sees `b_valid` only when a permitted port command targets it. `b_we` follows that port's write flag. The port's `m_cmd_ready` is high exactly in the cycle its bank has both `b_valid` and `b_ready` high. That is the one cycle in which the command is accepted.
- R3: With no lock held, competing ports are served in round-robin order, starting from the port after the last one accepted on that bank. After reset, port 0 has the highest priority.
- R4: While `b_lock` of a bank is high, only the port last accepted on that bank can be forwarded to it. Any other port waits until the lock falls.
- R5: Every accepted command is recorded once. The data events of a bank are assigned to its accepted commands in acceptance order, even when the commands come from different ports.
- R6: Exactly WR_LAT cycles (default 1) after `b_wdata_ready` of a bank, `m_wdata_ack` of the owning port is high. In that same cycle, `ctl_wdata` and `ctl_wbe` carry that port's `m_wdata` and `m_wbe`.
- R7: Exactly RD_LAT cycles (default 5) after `b_rdata_valid` of a bank, `m_rdata_valid` of the owning port is high. In that cycle, `m_rdata` equals `ctl_rdata`.
- R8: PORT_MODE holds 2 bits per port: bit 2m allows reads and bit 2m+1 allows writes. The default gives port 3 read-only, port 2 write-only, and ports 0 and 1 both. A forbidden command never raises any `b_valid` and never gets `m_cmd_ready`.
- R9: While a bank's queue holds TRACK_DEPTH outstanding commands, `b_valid` of that bank stays low. It returns once a data event frees an entry.
- R10: After reset and while idle, `b_valid`, `m_cmd_ready`, `m_wdata_ack` and `m_rdata_valid` are all zero.
- R11: In a cycle with no write-data transfer, `ctl_wbe` and `ctl_wdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_cmd_valid | input | NUM_MASTERS | Command request per port |
| m_cmd_ready | output | NUM_MASTERS | Command accepted this cycle |
| m_cmd_we | input | NUM_MASTERS | 1 = write, 0 = read |
| m_cmd_addr | input | NUM_MASTERS*AW | Flat addresses, port m at [m*AW +: AW] |
| m_wdata | input | NUM_MASTERS*DATA_W | Write data per port |
| m_wbe | input | NUM_MASTERS*DATA_W/8 | Byte enables per port |
| m_wdata_ack | output | NUM_MASTERS | Port's write data is taken this cycle |
| m_rdata_valid | output | NUM_MASTERS | Read data on m_rdata belongs to this port |
| m_rdata | output | DATA_W | Shared read data |
| b_valid | output | NUM_BANKS | Command presented to bank |
| b_ready | input | NUM_BANKS | Bank accepts command |
| b_we | output | NUM_BANKS | Command is a write |
| b_addr | output | NUM_BANKS*BAW | Row/column address per bank |
| b_lock | input | NUM_BANKS | Bank is held by its current port |
| b_wdata_ready | input | NUM_BANKS | Bank starts a write-data transfer |
| b_rdata_valid | input | NUM_BANKS | Bank starts a read-data transfer |
| ctl_wdata | output | DATA_W | Shared write data |
| ctl_wbe | output | DATA_W/8 | Shared byte enables |
| ctl_rdata | input | DATA_W | Shared read data from the PHY |

## Verification
A write-data event on one bank and a read-data event on another bank can occur in the same cycle. Each event then pops its own bank queue and feeds its own latency pipe. The bench raises `b_wdata_ready` on one bank and `b_rdata_valid` on another bank on the same edge, with the two queues owned by different ports. It then expects the write acknowledge at the first port exactly WR_LAT cycles later, carrying only that port's data. It expects the read valid at the second port exactly RD_LAT cycles later, and confirms that neither event leaks onto the other port's strobe.

// File: rtl/dram_xbar_pkg.sv
package dram_xbar_pkg;

    // Per-port permission, bit 0 = read allowed, bit 1 = write allowed
    typedef enum logic [1:0] {
        PERM_NONE  = 2'b00,
        PERM_READ  = 2'b01,
        PERM_WRITE = 2'b10,
        PERM_BOTH  = 2'b11
    } port_perm_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/dram_xbar_bank_arb.sv
module dram_xbar_bank_arb
    import dram_xbar_pkg::*;
#(
    parameter int NM = 4,
    localparam int MIW = idx_width(NM)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NM-1:0]  req,
    input  logic           lock,
    input  logic           accept,
    output logic           gnt_any,
    output logic [MIW-1:0] gnt_idx
);

    typedef struct packed {
        logic [MIW-1:0] last;
    } arb_st_t;

    arb_st_t s_d, s_q;

    always_comb begin
        int k;
        s_d     = s_q;
        gnt_any = 1'b0;
        gnt_idx = s_q.last;
        k       = 0;
        if (lock) begin
            // bank is tied to the port it last accepted
            gnt_any = req[s_q.last];
        end else begin
            // smallest distance after the last winner is written last
            for (int i = NM; i >= 1; i--) begin
                k = (int'(s_q.last) + i) % NM;
                if (req[k]) begin
                    gnt_any = 1'b1;
                    gnt_idx = MIW'(k);
                end
            end
        end
        if (accept) begin
            s_d.last = gnt_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.last <= MIW'(NM - 1);
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/dram_xbar_tag_fifo.sv
module dram_xbar_tag_fifo
    import dram_xbar_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int TW    = 2,
    localparam int PW   = idx_width(DEPTH),
    localparam int CNW  = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [TW-1:0] push_tag,
    input  logic          pop,
    output logic [TW-1:0] head_tag,
    output logic          empty,
    output logic          full
);

    typedef struct packed {
        logic [DEPTH-1:0][TW-1:0] mem;
        logic [PW-1:0]            rd;
        logic [PW-1:0]            wr;
        logic [CNW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t s_d, s_q;
    logic     do_push, do_pop;

    assign empty    = (s_q.cnt == '0);
    assign full     = (s_q.cnt == CNW'(DEPTH));
    assign head_tag = s_q.mem[s_q.rd];
    assign do_push  = push && !full;
    assign do_pop   = pop && !empty;

    always_comb begin
        s_d = s_q;
        if (do_push) begin
            s_d.mem[s_q.wr] = push_tag;
            s_d.wr = (s_q.wr == PW'(DEPTH - 1)) ? '0 : s_q.wr + 1'b1;
        end
        if (do_pop) begin
            s_d.rd = (s_q.rd == PW'(DEPTH - 1)) ? '0 : s_q.rd + 1'b1;
        end
        s_d.cnt = s_q.cnt + CNW'(do_push) - CNW'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/dram_xbar_lat_pipe.sv
module dram_xbar_lat_pipe #(
    parameter int LAT = 1,
    parameter int W   = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld,
    input  logic [W-1:0] in_tag,
    output logic         out_vld,
    output logic [W-1:0] out_tag
);

    typedef struct packed {
        logic [LAT-1:0]        vld;
        logic [LAT-1:0][W-1:0] tag;
    } pipe_st_t;

    pipe_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int i = LAT - 1; i >= 1; i--) begin
            s_d.vld[i] = s_q.vld[i-1];
            s_d.tag[i] = s_q.tag[i-1];
        end
        s_d.vld[0] = in_vld;
        s_d.tag[0] = in_tag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_vld = s_q.vld[LAT-1];
    assign out_tag = s_q.tag[LAT-1];

endmodule

// File: rtl/dram_bank_xbar.sv
module dram_bank_xbar
    import dram_xbar_pkg::*;
#(
    parameter int NUM_MASTERS = 4,
    parameter int BANK_BITS   = 3,
    parameter int ROW_BITS    = 13,
    parameter int COL_BITS    = 10,
    parameter int BURST_ALIGN = 1,
    parameter int DATA_W      = 32,
    parameter int WR_LAT      = 1,
    parameter int RD_LAT      = 5,
    parameter int TRACK_DEPTH = 4,
    parameter logic [2*NUM_MASTERS-1:0] PORT_MODE = {PERM_READ, PERM_WRITE, PERM_BOTH, PERM_BOTH},
    localparam int NB  = 1 << BANK_BITS,
    localparam int CW  = COL_BITS - BURST_ALIGN,
    localparam int AW  = ROW_BITS + BANK_BITS + CW,
    localparam int BAW = ROW_BITS + CW,
    localparam int BEW = DATA_W / 8,
    localparam int MIW = idx_width(NUM_MASTERS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_MASTERS-1:0]        m_cmd_valid,
    output logic [NUM_MASTERS-1:0]        m_cmd_ready,
    input  logic [NUM_MASTERS-1:0]        m_cmd_we,
    input  logic [NUM_MASTERS*AW-1:0]     m_cmd_addr,
    input  logic [NUM_MASTERS*DATA_W-1:0] m_wdata,
    input  logic [NUM_MASTERS*BEW-1:0]    m_wbe,
    output logic [NUM_MASTERS-1:0]        m_wdata_ack,
    output logic [NUM_MASTERS-1:0]        m_rdata_valid,
    output logic [DATA_W-1:0]             m_rdata,
    output logic [NB-1:0]                 b_valid,
    input  logic [NB-1:0]                 b_ready,
    output logic [NB-1:0]                 b_we,
    output logic [NB*BAW-1:0]             b_addr,
    input  logic [NB-1:0]                 b_lock,
    input  logic [NB-1:0]                 b_wdata_ready,
    input  logic [NB-1:0]                 b_rdata_valid,
    output logic [DATA_W-1:0]             ctl_wdata,
    output logic [BEW-1:0]                ctl_wbe,
    input  logic [DATA_W-1:0]             ctl_rdata
);

    localparam int NM = NUM_MASTERS;

    // per-port decode
    logic [BANK_BITS-1:0] port_bank [NM];
    logic [NM-1:0]        port_legal;

    // per-bank arbitration and tracking
    logic [NM-1:0]        bank_req  [NB];
    logic [NB-1:0]        gnt_any;
    logic [MIW-1:0]       gnt_idx   [NB];
    logic [NB-1:0]        accept;
    logic [NB-1:0]        q_full;
    logic [NB-1:0]        q_empty;
    logic [NB-1:0]        q_pop;
    logic [MIW-1:0]       q_head    [NB];

    // data event selection
    logic                 wr_hit, rd_hit;
    logic [BANK_BITS-1:0] wr_bank, rd_bank;
    logic [MIW-1:0]       wr_owner, rd_owner;
    logic                 wr_out_vld, rd_out_vld;
    logic [MIW-1:0]       wr_out_tag, rd_out_tag;

    // address decode and permission check per port
    for (genvar m = 0; m < NM; m++) begin : g_port
        logic [AW-1:0] a;
        assign a             = m_cmd_addr[m*AW +: AW];
        assign port_bank[m]  = a[CW +: BANK_BITS];
        assign port_legal[m] = m_cmd_valid[m] &&
                               (m_cmd_we[m] ? PORT_MODE[2*m+1] : PORT_MODE[2*m]);
    end

    always_comb begin
        for (int b = 0; b < NB; b++) begin
            for (int m = 0; m < NM; m++) begin
                bank_req[b][m] = port_legal[m] && (port_bank[m] == BANK_BITS'(b));
            end
        end
    end

    // one arbiter and one owner queue per bank
    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic [AW-1:0] sel_addr;

        dram_xbar_bank_arb #(
            .NM (NM)
        ) arb_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (bank_req[b]),
            .lock    (b_lock[b]),
            .accept  (accept[b]),
            .gnt_any (gnt_any[b]),
            .gnt_idx (gnt_idx[b])
        );

        dram_xbar_tag_fifo #(
            .DEPTH (TRACK_DEPTH),
            .TW    (MIW)
        ) trk_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (accept[b]),
            .push_tag (gnt_idx[b]),
            .pop      (q_pop[b]),
            .head_tag (q_head[b]),
            .empty    (q_empty[b]),
            .full     (q_full[b])
        );

        assign sel_addr   = m_cmd_addr[int'(gnt_idx[b])*AW +: AW];
        assign b_valid[b] = gnt_any[b] && !q_full[b];
        assign b_we[b]    = m_cmd_we[gnt_idx[b]];
        assign b_addr[b*BAW +: BAW] = {sel_addr[AW-1 -: ROW_BITS], sel_addr[CW-1:0]};
        assign accept[b]  = b_valid[b] && b_ready[b];
    end

    // port handshake: a port is granted by at most the bank it addresses
    always_comb begin
        m_cmd_ready = '0;
        for (int b = 0; b < NB; b++) begin
            if (accept[b]) begin
                m_cmd_ready[gnt_idx[b]] = 1'b1;
            end
        end
    end

    // pick the bank that raised each data strobe (lowest wins if illegal)
    always_comb begin
        wr_hit  = 1'b0;
        rd_hit  = 1'b0;
        wr_bank = '0;
        rd_bank = '0;
        for (int b = NB - 1; b >= 0; b--) begin
            if (b_wdata_ready[b]) begin
                wr_hit  = 1'b1;
                wr_bank = BANK_BITS'(b);
            end
            if (b_rdata_valid[b]) begin
                rd_hit  = 1'b1;
                rd_bank = BANK_BITS'(b);
            end
        end
        wr_owner = q_head[wr_bank];
        rd_owner = q_head[rd_bank];
        for (int b = 0; b < NB; b++) begin
            q_pop[b] = (wr_hit && (wr_bank == BANK_BITS'(b))) ||
                       (rd_hit && (rd_bank == BANK_BITS'(b)));
        end
    end

    dram_xbar_lat_pipe #(
        .LAT (WR_LAT),
        .W   (MIW)
    ) wr_pipe_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (wr_hit),
        .in_tag  (wr_owner),
        .out_vld (wr_out_vld),
        .out_tag (wr_out_tag)
    );

    dram_xbar_lat_pipe #(
        .LAT (RD_LAT),
        .W   (MIW)
    ) rd_pipe_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (rd_hit),
        .in_tag  (rd_owner),
        .out_vld (rd_out_vld),
        .out_tag (rd_out_tag)
    );

    // shared datapath steering
    always_comb begin
        m_wdata_ack   = '0;
        m_rdata_valid = '0;
        ctl_wdata     = '0;
        ctl_wbe       = '0;
        if (wr_out_vld) begin
            m_wdata_ack[wr_out_tag] = 1'b1;
            ctl_wdata = m_wdata[int'(wr_out_tag)*DATA_W +: DATA_W];
            ctl_wbe   = m_wbe[int'(wr_out_tag)*BEW +: BEW];
        end
        if (rd_out_vld) begin
            m_rdata_valid[rd_out_tag] = 1'b1;
        end
    end

    assign m_rdata = ctl_rdata;

endmodule

// File: rtl/dram_bank_xbar_chk.sv
module dram_bank_xbar_chk
    import dram_xbar_pkg::*;
#(
    parameter int NUM_MASTERS = 4,
    parameter int BANK_BITS   = 3,
    parameter int ROW_BITS    = 13,
    parameter int COL_BITS    = 10,
    parameter int BURST_ALIGN = 1,
    parameter int DATA_W      = 32,
    parameter int WR_LAT      = 1,
    parameter int RD_LAT      = 5,
    parameter int TRACK_DEPTH = 4,
    parameter logic [2*NUM_MASTERS-1:0] PORT_MODE = {PERM_READ, PERM_WRITE, PERM_BOTH, PERM_BOTH},
    localparam int NB  = 1 << BANK_BITS,
    localparam int CW  = COL_BITS - BURST_ALIGN,
    localparam int AW  = ROW_BITS + BANK_BITS + CW,
    localparam int BEW = DATA_W / 8,
    localparam int MIW = idx_width(NUM_MASTERS),
    localparam int CNW = $clog2(TRACK_DEPTH + 2)
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_MASTERS-1:0]        m_cmd_valid,
    input logic [NUM_MASTERS-1:0]        m_cmd_ready,
    input logic [NUM_MASTERS-1:0]        m_cmd_we,
    input logic [NUM_MASTERS*AW-1:0]     m_cmd_addr,
    input logic [NUM_MASTERS-1:0]        m_wdata_ack,
    input logic [NUM_MASTERS-1:0]        m_rdata_valid,
    input logic [NB-1:0]                 b_valid,
    input logic [NB-1:0]                 b_ready,
    input logic [NB-1:0]                 b_lock,
    input logic [NB-1:0]                 b_wdata_ready,
    input logic [NB-1:0]                 b_rdata_valid,
    input logic [BEW-1:0]                ctl_wbe
);

    localparam int NM = NUM_MASTERS;

    typedef struct packed {
        logic [WR_LAT-1:0] wr_sr;
        logic [RD_LAT-1:0] rd_sr;
    } lat_st_t;

    lat_st_t lat_d, lat_q;

    always_comb begin
        lat_d = lat_q;
        lat_d.wr_sr = {lat_q.wr_sr, |b_wdata_ready} >> 0;
        lat_d.rd_sr = {lat_q.rd_sr, |b_rdata_valid} >> 0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    AST_WACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(m_wdata_ack)); // R6
    AST_RVALID_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(m_rdata_valid)); // R7
    AST_WR_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (|m_wdata_ack) == lat_q.wr_sr[WR_LAT-1]); // R6
    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (|m_rdata_valid) == lat_q.rd_sr[RD_LAT-1]); // R7
    AST_WBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(|m_wdata_ack) |-> (ctl_wbe == '0)); // R11

    for (genvar m = 0; m < NM; m++) begin : g_m
        AST_READY_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
            m_cmd_ready[m] |-> (m_cmd_valid[m] &&
                (m_cmd_we[m] ? PORT_MODE[2*m+1] : PORT_MODE[2*m]))); // R8
    end

    for (genvar b = 0; b < NB; b++) begin : g_b
        typedef struct packed {
            logic           seen;
            logic [MIW-1:0] last;
            logic [CNW-1:0] cnt;
        } bank_st_t;

        bank_st_t s_d, s_q;
        logic     any_req;
        logic     acc;
        logic     evt;

        assign acc = b_valid[b] && b_ready[b];
        assign evt = b_wdata_ready[b] || b_rdata_valid[b];

        always_comb begin
            any_req = 1'b0;
            s_d     = s_q;
            for (int m = 0; m < NM; m++) begin
                if (m_cmd_valid[m] && (m_cmd_addr[m*AW + CW +: BANK_BITS] == BANK_BITS'(b))) begin
                    any_req = 1'b1;
                    if (m_cmd_ready[m]) begin
                        s_d.last = MIW'(m);
                        s_d.seen = 1'b1;
                    end
                end
            end
            s_d.cnt = s_q.cnt + CNW'(acc) - CNW'(evt);
        end

        always_ff @(posedge clk) begin
            if (!rst_n) s_q <= '0;
            else        s_q <= s_d;
        end

        AST_BVALID_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            b_valid[b] |-> any_req); // R2
        AST_LOCK_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
            (b_lock[b] && s_q.seen && acc) |-> m_cmd_ready[s_q.last]); // R4
        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            (s_q.cnt >= CNW'(TRACK_DEPTH)) |-> !b_valid[b]); // R9
    end

endmodule

bind dram_bank_xbar dram_bank_xbar_chk #(
    .NUM_MASTERS (NUM_MASTERS),
    .BANK_BITS   (BANK_BITS),
    .ROW_BITS    (ROW_BITS),
    .COL_BITS    (COL_BITS),
    .BURST_ALIGN (BURST_ALIGN),
    .DATA_W      (DATA_W),
    .WR_LAT      (WR_LAT),
    .RD_LAT      (RD_LAT),
    .TRACK_DEPTH (TRACK_DEPTH),
    .PORT_MODE   (PORT_MODE)
) chk_i (.*);

// File: tb/dram_bank_xbar_tb_top.sv
module dram_bank_xbar_tb_top;

    localparam int NM  = 4;
    localparam int BB  = 3;
    localparam int RB  = 13;
    localparam int CB  = 10;
    localparam int AL  = 1;
    localparam int DW  = 32;
    localparam int WRL = 1;
    localparam int RDL = 5;
    localparam int NB  = 1 << BB;
    localparam int CW  = CB - AL;
    localparam int AW  = RB + BB + CW;
    localparam int BAW = RB + CW;
    localparam int BEW = DW / 8;
    localparam int NV  = 6;

    // vector: {master[1:0], we, bank[2:0], row[12:0], col[9:0]}
    localparam logic [28:0] VEC [NV] = '{
        {2'd0, 1'b1, 3'd2, 13'h0030, 10'h003},
        {2'd1, 1'b1, 3'd3, 13'h0030, 10'h003},
        {2'd2, 1'b1, 3'd2, 13'h00ab, 10'h013},
        {2'd3, 1'b0, 3'd1, 13'h0010, 10'h099},
        {2'd0, 1'b0, 3'd0, 13'h1fff, 10'h3ff},
        {2'd1, 1'b0, 3'd7, 13'h00cd, 10'h077}
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NM-1:0]        m_cmd_valid = '0;
    logic [NM-1:0]        m_cmd_ready;
    logic [NM-1:0]        m_cmd_we = '0;
    logic [NM*AW-1:0]     m_cmd_addr = '0;
    logic [NM*DW-1:0]     m_wdata;
    logic [NM*BEW-1:0]    m_wbe;
    logic [NM-1:0]        m_wdata_ack;
    logic [NM-1:0]        m_rdata_valid;
    logic [DW-1:0]        m_rdata;
    logic [NB-1:0]        b_valid;
    logic [NB-1:0]        b_ready = '0;
    logic [NB-1:0]        b_we;
    logic [NB*BAW-1:0]    b_addr;
    logic [NB-1:0]        b_lock = '0;
    logic [NB-1:0]        b_wdata_ready = '0;
    logic [NB-1:0]        b_rdata_valid = '0;
    logic [DW-1:0]        ctl_wdata;
    logic [BEW-1:0]       ctl_wbe;
    logic [DW-1:0]        ctl_rdata = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    assign m_wdata = {32'hD3D3_0003, 32'hC2C2_0002, 32'hB1B1_0001, 32'hA0A0_0000};
    assign m_wbe   = {4'h1, 4'hC, 4'h3, 4'hF};

    dram_bank_xbar dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .m_cmd_valid   (m_cmd_valid),
        .m_cmd_ready   (m_cmd_ready),
        .m_cmd_we      (m_cmd_we),
        .m_cmd_addr    (m_cmd_addr),
        .m_wdata       (m_wdata),
        .m_wbe         (m_wbe),
        .m_wdata_ack   (m_wdata_ack),
        .m_rdata_valid (m_rdata_valid),
        .m_rdata       (m_rdata),
        .b_valid       (b_valid),
        .b_ready       (b_ready),
        .b_we          (b_we),
        .b_addr        (b_addr),
        .b_lock        (b_lock),
        .b_wdata_ready (b_wdata_ready),
        .b_rdata_valid (b_rdata_valid),
        .ctl_wdata     (ctl_wdata),
        .ctl_wbe       (ctl_wbe),
        .ctl_rdata     (ctl_rdata)
    );

    function automatic logic [AW-1:0] port_addr(int bank, int row, int col);
        return {RB'(row), BB'(bank), CW'(col >> AL)};
    endfunction

    function automatic logic [BAW-1:0] bank_addr(int row, int col);
        return {RB'(row), CW'(col >> AL)};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_cmd(int m, logic we, int bank, int row, int col);
        m_cmd_valid[m]           = 1'b1;
        m_cmd_we[m]              = we;
        m_cmd_addr[m*AW +: AW]   = port_addr(bank, row, col);
    endtask

    // single command, accepted in the cycle it is presented
    task automatic issue(int m, logic we, int bank, int row, int col);
        @(negedge clk);
        set_cmd(m, we, bank, row, col);
        b_ready[bank] = 1'b1;
        #1;
        chk("R2 b_valid", 64'(b_valid[bank]), 64'd1);
        chk("R1 b_addr", 64'(b_addr[bank*BAW +: BAW]), 64'(bank_addr(row, col)));
        chk("R2 b_we", 64'(b_we[bank]), 64'(we));
        chk("R2 m_cmd_ready", 64'(m_cmd_ready), 64'(1 << m));
        @(negedge clk);
        m_cmd_valid[m] = 1'b0;
        b_ready[bank]  = 1'b0;
    endtask

    task automatic wr_event(int bank, int m);
        @(negedge clk);
        b_wdata_ready[bank] = 1'b1;
        #1;
        chk("R6 no early ack", 64'(m_wdata_ack), 64'd0);
        for (int k = 1; k <= WRL; k++) begin
            @(negedge clk);
            if (k == 1) b_wdata_ready[bank] = 1'b0;
        end
        #1;
        chk("R6 ack owner", 64'(m_wdata_ack), 64'(1 << m));
        chk("R6 wdata", 64'(ctl_wdata), 64'(m_wdata[m*DW +: DW]));
        chk("R6 wbe", 64'(ctl_wbe), 64'(m_wbe[m*BEW +: BEW]));
    endtask

    task automatic rd_event(int bank, int m, logic [DW-1:0] data);
        @(negedge clk);
        b_rdata_valid[bank] = 1'b1;
        for (int k = 1; k <= RDL; k++) begin
            @(negedge clk);
            if (k == 1) b_rdata_valid[bank] = 1'b0;
            if (k == RDL - 1) begin
                #1;
                chk("R7 no early valid", 64'(m_rdata_valid), 64'd0);
            end
            if (k == RDL) ctl_rdata = data;
        end
        #1;
        chk("R7 rvalid owner", 64'(m_rdata_valid), 64'(1 << m));
        chk("R7 rdata", 64'(m_rdata), 64'(data));
    endtask

    initial begin
        // R10 reset state
        repeat (3) @(negedge clk);
        #1;
        chk("R10 b_valid", 64'(b_valid), 64'd0);
        chk("R10 m_cmd_ready", 64'(m_cmd_ready), 64'd0);
        chk("R10 ack", 64'(m_wdata_ack), 64'd0);
        chk("R10 rvalid", 64'(m_rdata_valid), 64'd0);
        chk("R11 idle wbe", 64'(ctl_wbe), 64'd0);
        chk("R11 idle wdata", 64'(ctl_wdata), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // table walk: R1 decode, R2 handshake, R6/R7 data return
        for (int i = 0; i < NV; i++) begin
            int m, bk, row, col;
            logic we;
            m   = int'(VEC[i][28:27]);
            we  = VEC[i][26];
            bk  = int'(VEC[i][25:23]);
            row = int'(VEC[i][22:10]);
            col = int'(VEC[i][9:0]);
            issue(m, we, bk, row, col);
            if (we) wr_event(bk, m);
            else    rd_event(bk, m, 32'h5000_0000 + 32'(i));
        end

        // R3 round robin on bank 6, then R9 queue full
        @(negedge clk);
        set_cmd(0, 1'b1, 6, 1, 2);
        set_cmd(1, 1'b1, 6, 2, 4);
        set_cmd(2, 1'b1, 6, 3, 6);
        b_ready[6] = 1'b1;
        #1 chk("R3 first winner", 64'(m_cmd_ready), 64'b0001);
        @(negedge clk);
        m_cmd_valid[0] = 1'b0;
        #1 chk("R3 second winner", 64'(m_cmd_ready), 64'b0010);
        @(negedge clk);
        m_cmd_valid[1] = 1'b0;
        m_cmd_valid[0] = 1'b1;
        #1 chk("R3 skip to after last", 64'(m_cmd_ready), 64'b0100);
        @(negedge clk);
        m_cmd_valid[2] = 1'b0;
        #1 chk("R3 wrap to port0", 64'(m_cmd_ready), 64'b0001);
        @(negedge clk);
        m_cmd_valid[0] = 1'b0;
        m_cmd_valid[1] = 1'b1;
        #1;
        chk("R9 full blocks b_valid", 64'(b_valid[6]), 64'd0);
        chk("R9 full blocks ready", 64'(m_cmd_ready), 64'd0);
        @(negedge clk);
        #1 chk("R9 still blocked", 64'(b_valid[6]), 64'd0);
        @(negedge clk);
        m_cmd_valid[1] = 1'b0;
        b_ready[6] = 1'b0;
        // R5 acceptance order survives across ports
        wr_event(6, 0);
        wr_event(6, 1);
        wr_event(6, 2);
        wr_event(6, 0);
        issue(1, 1'b1, 6, 2, 4);
        wr_event(6, 1);

        // R4 lock on bank 1
        issue(0, 1'b0, 1, 7, 8);
        @(negedge clk);
        b_lock[1] = 1'b1;
        set_cmd(0, 1'b0, 1, 7, 8);
        set_cmd(1, 1'b0, 1, 9, 10);
        b_ready[1] = 1'b1;
        #1 chk("R4 owner keeps bank", 64'(m_cmd_ready), 64'b0001);
        @(negedge clk);
        m_cmd_valid[0] = 1'b0;
        #1;
        chk("R4 other port blocked", 64'(b_valid[1]), 64'd0);
        chk("R4 no ready while locked", 64'(m_cmd_ready), 64'd0);
        @(negedge clk);
        #1 chk("R4 still blocked", 64'(m_cmd_ready), 64'd0);
        @(negedge clk);
        b_lock[1] = 1'b0;
        #1 chk("R4 released", 64'(m_cmd_ready), 64'b0010);
        @(negedge clk);
        m_cmd_valid[1] = 1'b0;
        b_ready[1] = 1'b0;
        rd_event(1, 0, 32'h0A0A_0001);
        rd_event(1, 0, 32'h0A0A_0002);
        rd_event(1, 1, 32'h0A0A_0003);

        // R8 port permissions on bank 5
        @(negedge clk);
        set_cmd(3, 1'b1, 5, 4, 4);
        b_ready[5] = 1'b1;
        #1;
        chk("R8 write from read-only port", 64'(b_valid), 64'd0);
        chk("R8 no ready read-only", 64'(m_cmd_ready), 64'd0);
        @(negedge clk);
        m_cmd_valid[3] = 1'b0;
        set_cmd(2, 1'b0, 5, 4, 4);
        #1;
        chk("R8 read from write-only port", 64'(b_valid), 64'd0);
        chk("R8 no ready write-only", 64'(m_cmd_ready), 64'd0);
        @(negedge clk);
        m_cmd_valid[2] = 1'b0;
        b_ready[5] = 1'b0;
        issue(3, 1'b0, 5, 4, 4);
        rd_event(5, 3, 32'h0B0B_0005);

        // write and read events on different banks in the same cycle (R6, R7)
        issue(0, 1'b1, 2, 11, 12);
        issue(1, 1'b0, 4, 13, 14);
        @(negedge clk);
        b_wdata_ready[2] = 1'b1;
        b_rdata_valid[4] = 1'b1;
        for (int k = 1; k <= RDL; k++) begin
            @(negedge clk);
            if (k == 1) begin
                b_wdata_ready[2] = 1'b0;
                b_rdata_valid[4] = 1'b0;
            end
            if (k == WRL) begin
                #1;
                chk("R6 same-cycle ack", 64'(m_wdata_ack), 64'b0001);
                chk("R6 same-cycle wdata", 64'(ctl_wdata), 64'hA0A0_0000);
                chk("R7 no rvalid yet", 64'(m_rdata_valid), 64'd0);
            end
            if (k == RDL) ctl_rdata = 32'h0C0C_0004;
        end
        #1;
        chk("R7 same-cycle rvalid", 64'(m_rdata_valid), 64'b0010);
        chk("R7 same-cycle rdata", 64'(m_rdata), 64'h0C0C_0004);
        chk("R11 no write slot", 64'(ctl_wbe), 64'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule